// File: doc/BRIEF.md
# Two-Tone Square-Wave Discriminator

This block decides which of two square-wave tones is present on a single digital input and reports the answer as one result bit. The raw input first passes through a synchroniser. It is then resampled on a slow tick, whose period the user sets with a divider value. While the resampled level is high, a toggle flop flips on every system clock. While the level is low, the flop holds its state.

At each falling edge of the resampled level, the flop's final state is captured into a short history. The toggle count in a high phase equals the number of clocks that phase lasts, so the captured bit flips from phase to phase only when that count is odd. For one tone the captured bit is steady, and for the other it alternates.

The last four captures decide the result. A valid flag shows that the answer has been confirmed over four complete phases since reset, or since the result last changed.

Top module: `tone_discriminator`

## Requirements
- R1: While synchronous reset `rst` is high at a clock edge, `result` and `valid` are 0 after that edge.
- R2: The resampled level changes only on a resample tick. Ticks occur once every `divCfg`+1 system clocks. The toggle flop flips once per clock while the resampled level is high and never while it is low. Each high phase therefore contributes L = (`divCfg`+1) × (ticks sampled high) toggles.
- R3: When every high phase of a steady tone gives an odd L, the captured bit alternates and `result` settles to 1.
- R4: When every high phase of a steady tone gives an even L, the captured bit is constant and `result` settles to 0.
- R5: `valid` stays 0 until four high phases have been captured since reset.
- R6: When the last four captures are neither all alternating nor all equal, `result` keeps its previous value.
- R7: A change of `result` clears `valid` in the same cycle. `valid` returns once four further phases have been captured without another change.
- R8: While the input shows no falling edge, `result` and `valid` hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| toneIn | input | 1 | Raw square-wave tone input, asynchronous |
| divCfg | input | DIV_W | Resample tick period minus one, in system clocks |
| result | output | 1 | 1 when high phases give an odd toggle count, 0 when even |
| valid | output | 1 | Result confirmed over four phases since reset or last change |

## Verification
The bench sweeps every divider setting from 0 to 3 against square waves whose half period is 1 to 4 tick periods. Each resulting L has a parity the bench works out as a product. This separates the alternating case from the steady case across all combinations of tick period and tone length.

A tone whose half period alternates between odd and even lengths shows that a mixed history leaves the result unchanged, from either starting value. A reset followed by only three periods shows that valid waits for the fourth phase. Long idle stretches show that the outputs hold when no phase ends. The bench also watches every change of the result to confirm that valid drops at that moment.

// File: rtl/td_pkg.sv
package td_pkg;
  typedef struct packed {
    logic sampleTick;
    logic capture;
  } tdStrobe_t;
endpackage

// File: rtl/td_datapath.sv
module td_datapath
  import td_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int HIST_LEN    = 4
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                toneIn,
  input  tdStrobe_t           ctl,
  output logic                rsLevel,
  output logic [HIST_LEN-1:0] history
);
  logic [SYNC_STAGES-1:0] syncQ;
  logic                   syncOut;
  logic                   togQ;

  generate
    if (SYNC_STAGES == 1) begin : g_sync1
      always_ff @(posedge clk) begin
        if (rst) syncQ <= '0;
        else     syncQ <= toneIn;
      end
    end else begin : g_syncN
      always_ff @(posedge clk) begin
        if (rst) syncQ <= '0;
        else     syncQ <= {syncQ[SYNC_STAGES-2:0], toneIn};
      end
    end
  endgenerate

  assign syncOut = syncQ[SYNC_STAGES-1];

  always_ff @(posedge clk) begin
    if (rst)                 rsLevel <= 1'b0;
    else if (ctl.sampleTick) rsLevel <= syncOut;
  end

  always_ff @(posedge clk) begin
    if (rst)          togQ <= 1'b0;
    else if (rsLevel) togQ <= ~togQ;
  end

  always_ff @(posedge clk) begin
    if (rst)              history <= '0;
    else if (ctl.capture) history <= {history[HIST_LEN-2:0], togQ};
  end

  // R2: resampled level moves only after a tick
  a_r2_level_moves_on_tick: assert property (@(posedge clk) disable iff (rst)
    (rsLevel != $past(rsLevel)) |-> $past(ctl.sampleTick));

  // R2: toggle flop frozen while resampled level is low
  a_r2_toggle_frozen_low: assert property (@(posedge clk) disable iff (rst)
    (!$past(rsLevel)) |-> (togQ == $past(togQ)));

  // R2: newest history entry is the toggle state at capture
  a_r2_capture_takes_toggle: assert property (@(posedge clk) disable iff (rst)
    ctl.capture |=> (history[0] == $past(togQ)));
endmodule

// File: rtl/td_control.sv
module td_control
  import td_pkg::*;
#(
  parameter int DIV_W    = 8,
  parameter int HIST_LEN = 4
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [DIV_W-1:0]    divCfg,
  input  logic                rsLevel,
  input  logic [HIST_LEN-1:0] history,
  output tdStrobe_t           ctl,
  output logic                result,
  output logic                valid
);
  localparam int CNT_W = $clog2(HIST_LEN + 1);
  localparam logic [CNT_W-1:0] FULL = CNT_W'(HIST_LEN);

  logic [DIV_W-1:0]    divCnt;
  logic                tick;
  logic                rsDly;
  logic                capDly;
  logic [CNT_W-1:0]    fillCnt;
  logic [CNT_W-1:0]    validCnt;
  logic [HIST_LEN-2:0] diffVec;
  logic                allDiff;
  logic                allSame;
  logic                decide;
  logic                nextRes;
  logic                changed;

  assign tick = (divCnt >= divCfg);

  always_ff @(posedge clk) begin
    if (rst)       divCnt <= '0;
    else if (tick) divCnt <= '0;
    else           divCnt <= divCnt + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rsDly  <= 1'b0;
      capDly <= 1'b0;
    end else begin
      rsDly  <= rsLevel;
      capDly <= ctl.capture;
    end
  end

  always_comb begin
    ctl.sampleTick = tick;
    ctl.capture    = rsDly & ~rsLevel;
  end

  genvar gi;
  generate
    for (gi = 0; gi < HIST_LEN - 1; gi++) begin : g_diff
      assign diffVec[gi] = history[gi] ^ history[gi+1];
    end
  endgenerate

  assign allDiff = &diffVec;
  assign allSame = ~|diffVec;
  assign decide  = capDly && (fillCnt == FULL);

  always_comb begin
    nextRes = result;
    if (decide) begin
      if (allDiff)      nextRes = 1'b1;
      else if (allSame) nextRes = 1'b0;
    end
  end

  assign changed = (nextRes != result);

  always_ff @(posedge clk) begin
    if (rst)                              fillCnt <= '0;
    else if (ctl.capture && fillCnt != FULL) fillCnt <= fillCnt + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      result   <= 1'b0;
      validCnt <= '0;
    end else if (capDly) begin
      result <= nextRes;
      if (changed)               validCnt <= '0;
      else if (validCnt != FULL) validCnt <= validCnt + 1'b1;
    end
  end

  assign valid = (validCnt == FULL);

  // R7: a changed result is never reported valid
  a_r7_change_clears_valid: assert property (@(posedge clk) disable iff (rst)
    (result != $past(result)) |-> !valid);

  // R6/R8: result moves only right after a capture
  a_r8_result_moves_after_capture: assert property (@(posedge clk) disable iff (rst)
    (result != $past(result)) |-> $past(capDly));

  // R5: valid rises only after a capture
  a_r5_valid_rises_after_capture: assert property (@(posedge clk) disable iff (rst)
    $rose(valid) |-> $past(capDly));

  // R5: valid needs a full history
  a_r5_valid_needs_history: assert property (@(posedge clk) disable iff (rst)
    valid |-> (fillCnt == FULL));
endmodule

// File: rtl/tone_discriminator.sv
module tone_discriminator
  import td_pkg::*;
#(
  parameter int DIV_W       = 8,
  parameter int SYNC_STAGES = 2,
  parameter int HIST_LEN    = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             toneIn,
  input  logic [DIV_W-1:0] divCfg,
  output logic             result,
  output logic             valid
);
  tdStrobe_t           ctl;
  logic                rsLevel;
  logic [HIST_LEN-1:0] history;

  td_datapath #(.SYNC_STAGES(SYNC_STAGES), .HIST_LEN(HIST_LEN)) u_dp (
    .clk     (clk),
    .rst     (rst),
    .toneIn  (toneIn),
    .ctl     (ctl),
    .rsLevel (rsLevel),
    .history (history)
  );

  td_control #(.DIV_W(DIV_W), .HIST_LEN(HIST_LEN)) u_ctl (
    .clk     (clk),
    .rst     (rst),
    .divCfg  (divCfg),
    .rsLevel (rsLevel),
    .history (history),
    .ctl     (ctl),
    .result  (result),
    .valid   (valid)
  );

  // R1: outputs cleared in the cycle after a reset edge
  a_r1_reset_clears: assert property (@(posedge clk)
    rst |=> (!result && !valid));
endmodule

// File: tb/tone_discriminator_bench.sv
module tone_discriminator_bench;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       toneIn = 1'b0;
  logic [7:0] divCfg = 8'd0;
  logic       result;
  logic       valid;

  int checks = 0;
  int errors = 0;
  int monChecks = 0;
  int monErrors = 0;
  logic prevRes = 1'b0;
  logic done = 1'b0;

  always #2.5 clk = ~clk;

  tone_discriminator u_tone_discriminator (
    .clk(clk), .rst(rst), .toneIn(toneIn), .divCfg(divCfg),
    .result(result), .valid(valid)
  );

  task automatic check(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0b expected=%0b", req, act, exp);
    end
  endtask

  task automatic runTone(input int half, input int periods);
    for (int p = 0; p < periods; p++) begin
      toneIn = 1'b1;
      repeat (half) @(negedge clk);
      toneIn = 1'b0;
      repeat (half) @(negedge clk);
    end
  endtask

  task automatic settle();
    repeat (int'(divCfg) * 2 + 12) @(negedge clk);
  endtask

  // R7: every change of result must come with valid low
  always @(negedge clk) begin
    if (!rst) begin
      if (result !== prevRes) begin
        monChecks++;
        if (valid !== 1'b0) begin
          monErrors++;
          $display("FAIL R7 actual=%0b expected=0 (valid at result change)", valid);
        end
      end
      prevRes = result;
    end
  end

  task automatic report(input int extra);
    $display("CHECKS %0d ERRORS %0d", checks + monChecks + extra, errors + monErrors + extra);
    $finish;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R1 result", result, 1'b0);
    check("R1 valid", valid, 1'b0);
    rst = 1'b0;

    // R5: three phases are not enough for valid
    divCfg = 8'd0;
    runTone(4, 3);
    settle();
    check("R5 valid after three phases", valid, 1'b0);
    runTone(4, 4);
    settle();
    check("R5 valid after seven phases", valid, 1'b1);
    check("R4 even length steady", result, 1'b0);

    // R2/R3/R4: sweep tick period and half-period length
    for (int d = 0; d < 4; d++) begin
      for (int m = 1; m <= 4; m++) begin
        logic expRes;
        divCfg = 8'(d);
        expRes = ((m * (d + 1)) % 2) == 1;
        runTone(m * (d + 1), 12);
        settle();
        if (expRes) check("R3 odd toggle count gives 1 (R2 sweep)", result, 1'b1);
        else        check("R4 even toggle count gives 0 (R2 sweep)", result, 1'b0);
        check("R7 valid after steady tone", valid, 1'b1);
      end
    end

    // R6: mixed lengths keep result at 1
    divCfg = 8'd0;
    runTone(5, 12);
    settle();
    check("R3 before mixed", result, 1'b1);
    for (int k = 0; k < 8; k++) begin
      runTone(3, 1);
      runTone(4, 1);
      check("R6 mixed keeps 1", result, 1'b1);
    end

    // R6: mixed lengths keep result at 0
    runTone(4, 12);
    settle();
    check("R4 before mixed", result, 1'b0);
    for (int k = 0; k < 8; k++) begin
      runTone(3, 1);
      runTone(4, 1);
      check("R6 mixed keeps 0", result, 1'b0);
    end

    // R8: idle input holds outputs
    runTone(5, 12);
    settle();
    repeat (200) @(negedge clk);
    check("R8 idle low keeps result", result, 1'b1);
    check("R8 idle low keeps valid", valid, 1'b1);
    toneIn = 1'b1;
    repeat (200) @(negedge clk);
    check("R8 held high keeps result", result, 1'b1);
    check("R8 held high keeps valid", valid, 1'b1);
    toneIn = 1'b0;
    settle();

    // R1: reset in mid-run
    rst = 1'b1;
    repeat (2) @(negedge clk);
    check("R1 result after late reset", result, 1'b0);
    check("R1 valid after late reset", valid, 1'b0);
    rst = 1'b0;
    repeat (4) @(negedge clk);
    done = 1'b1;
    report(0);
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      $display("FAIL watchdog actual=timeout expected=finish");
      report(1);
    end
  end
endmodule